// File: doc/BRIEF.md
# Dual-Priority Transmit Descriptor Fetcher

This block walks two rings of transmit descriptors held in system memory: an urgent ring and a normal ring. A kick pulse starts a pass. The urgent ring is walked first, and only if it is switched on and its base is nonzero. The normal ring is walked next if its base is nonzero. Each descriptor is 16 bytes long. The block fetches it one 32-bit word at a time over a simple request/acknowledge memory port and first checks the ownership flag. For each descriptor owned by hardware, the block hands one segment request to a downstream frame assembler. It then writes the control word back with ownership returned to software, and pulses the interrupt status bits that the descriptor asked for.

The walk of a ring stops at the first descriptor still owned by software. That event pulses an out-of-buffers status bit. Each ring keeps its own index, which advances by one per descriptor or returns to zero when the descriptor carries an end-of-ring marker. Payload movement, checksum work and the line side belong to other blocks.

Top module: `txdesc_walker`

## Requirements
- R1: After reset both ring indices read 0, and `mem_req`, `seg_valid`, `busy`, `status_set` and `misalign_err` are all low.
- R2: A descriptor lives at base + index*16. Its words are read in the order offset 0 (control), offset 4 (options), offset 12 (buffer address), and word 2 is never read.
- R3: A descriptor with control bit 31 = 1 produces exactly one segment. The segment carries: buffer address = word at offset 12; length = control[13:0]; first = control[29]; last = control[28]; crc_err = control[19]; vlan_en = options[16]; vlan_tag = options[15:0].
- R4: After its segment is accepted, the control word is written back to the same address with bit 31 cleared and every other bit unchanged.
- R5: A descriptor with control bit 31 = 0 yields no segment and no write. It ends the walk of that ring and pulses `status_set[6]` for one cycle.
- R6: After write-back, options bit 30 pulses `status_set[5]` and options bit 31 pulses `status_set[4]`, each for one cycle.
- R7: After write-back, the ring index returns to 0 if control bit 15 is set, and otherwise increments by 1.
- R8: With `hp_en` = 1 and `hp_base` nonzero, the urgent ring is walked to its stop before any normal-ring descriptor is read. `seg_hp` marks urgent segments.
- R9: With `hp_en` = 0, the urgent ring is not read and `hp_idx` keeps its value.
- R10: A kick while `tx_en` or `txdma_en` is low issues no memory request and changes no index.
- R11: A descriptor whose address has bits [3:0] nonzero pulses `misalign_err` once, and the descriptor is still processed normally.
- R12: A kick that arrives while a pass is running is held. It starts one further pass once the current one ends.
- R13: Once `mem_req` is raised, the request stays raised with the same address, write flag and data until `mem_ack`. Once `seg_valid` is raised, the segment stays valid with unchanged fields until `seg_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kick | input | 1 | Start-of-pass pulse |
| tx_en | input | 1 | Transmit enable |
| txdma_en | input | 1 | Transmit DMA enable |
| hp_en | input | 1 | Urgent ring enable |
| hp_base | input | AW | Urgent ring base address |
| np_base | input | AW | Normal ring base address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address (byte units) |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access done; read data valid this cycle |
| mem_rdata | input | 32 | Read data |
| seg_valid | output | 1 | Segment request valid |
| seg_ready | input | 1 | Assembler accepts segment |
| seg_hp | output | 1 | Segment comes from the urgent ring |
| seg_addr | output | 32 | Buffer address |
| seg_len | output | 14 | Buffer length in bytes |
| seg_first | output | 1 | First segment of frame |
| seg_last | output | 1 | Last segment of frame |
| seg_crc_err | output | 1 | Force bad CRC |
| seg_vlan_en | output | 1 | Insert VLAN tag |
| seg_vlan_tag | output | 16 | VLAN tag value |
| status_set | output | 3 | One-cycle status pulses at positions 6:4 (6 out-of-buffers, 5 FIFO done, 4 line done) |
| misalign_err | output | 1 | One-cycle pulse for an unaligned descriptor |
| hp_idx | output | IW | Urgent ring index |
| np_idx | output | IW | Normal ring index |
| busy | output | 1 | Pass running or kick pending |

## Verification
Every descriptor costs three read handshakes, one segment handshake and one write handshake. The status, misalign and index results are registered at the acknowledge edge that produces them, so they show up one cycle after that edge. The bench therefore does not predict exact cycles. It waits for `busy` to fall and then lets two more clock edges pass, which is enough for the last registered pulse to be counted. All checks sample on the falling edge. Results are judged from counted pulses and logged segments taken over the whole pass, and from memory contents and index ports read once the pass has settled.

// File: rtl/txdesc_walker.sv
module txdesc_walker #(
  parameter int AW = 32,
  parameter int IW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kick,
  input  logic          tx_en,
  input  logic          txdma_en,
  input  logic          hp_en,
  input  logic [AW-1:0] hp_base,
  input  logic [AW-1:0] np_base,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          seg_valid,
  input  logic          seg_ready,
  output logic          seg_hp,
  output logic [31:0]   seg_addr,
  output logic [13:0]   seg_len,
  output logic          seg_first,
  output logic          seg_last,
  output logic          seg_crc_err,
  output logic          seg_vlan_en,
  output logic [15:0]   seg_vlan_tag,
  output logic [6:4]    status_set,
  output logic          misalign_err,
  output logic [IW-1:0] hp_idx,
  output logic [IW-1:0] np_idx,
  output logic          busy
);
  localparam int PADW = AW - IW - 4;

  typedef enum logic [2:0] {S_IDLE, S_RD0, S_RD1, S_RD3, S_SEG, S_WB} st_t;

  st_t          st;
  logic         ring_hp, kick_pend;
  logic [31:0]  ctl, bufa;
  logic [18:0]  opt;
  logic [AW-1:0] desc_addr;
  logic [3:0]   woff;

  wire go    = tx_en & txdma_en;
  wire hp_ok = hp_en & (|hp_base);
  wire np_ok = |np_base;
  wire [IW-1:0] cur_idx = ring_hp ? hp_idx : np_idx;

  assign desc_addr = (ring_hp ? hp_base : np_base) + {{PADW{1'b0}}, cur_idx, 4'b0000};

  always_comb begin
    case (st)
      S_RD1:   woff = 4'd4;
      S_RD3:   woff = 4'd12;
      default: woff = 4'd0;
    endcase
  end

  assign mem_req   = (st == S_RD0) | (st == S_RD1) | (st == S_RD3) | (st == S_WB);
  assign mem_we    = (st == S_WB);
  assign mem_addr  = desc_addr + {{(AW-4){1'b0}}, woff};
  assign mem_wdata = {1'b0, ctl[30:0]};

  assign seg_valid    = (st == S_SEG);
  assign seg_hp       = ring_hp;
  assign seg_addr     = bufa;
  assign seg_len      = ctl[13:0];
  assign seg_first    = ctl[29];
  assign seg_last     = ctl[28];
  assign seg_crc_err  = ctl[19];
  assign seg_vlan_en  = opt[16];
  assign seg_vlan_tag = opt[15:0];
  assign busy         = (st != S_IDLE) | kick_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      ring_hp      <= 1'b0;
      kick_pend    <= 1'b0;
      ctl          <= '0;
      opt          <= '0;
      bufa         <= '0;
      hp_idx       <= '0;
      np_idx       <= '0;
      status_set   <= '0;
      misalign_err <= 1'b0;
    end else begin
      status_set   <= '0;
      misalign_err <= 1'b0;
      if (st != S_IDLE && kick) kick_pend <= 1'b1;
      case (st)
        S_IDLE: if (kick | kick_pend) begin
          kick_pend <= 1'b0;
          if (go && (hp_ok || np_ok)) begin
            ring_hp <= hp_ok;
            st      <= S_RD0;
          end
        end
        S_RD0: if (mem_ack) begin
          ctl          <= mem_rdata;
          misalign_err <= |desc_addr[3:0];
          if (mem_rdata[31]) st <= S_RD1;
          else begin
            status_set[6] <= 1'b1;
            if (ring_hp && np_ok) ring_hp <= 1'b0;
            else st <= S_IDLE;
          end
        end
        S_RD1: if (mem_ack) begin
          opt <= {mem_rdata[31:30], mem_rdata[16:0]};
          st  <= S_RD3;
        end
        S_RD3: if (mem_ack) begin
          bufa <= mem_rdata;
          st   <= S_SEG;
        end
        S_SEG: if (seg_ready) st <= S_WB;
        S_WB: if (mem_ack) begin
          status_set[5] <= opt[17];
          status_set[4] <= opt[18];
          if (ring_hp) hp_idx <= ctl[15] ? '0 : hp_idx + 1'b1;
          else         np_idx <= ctl[15] ? '0 : np_idx + 1'b1;
          st <= S_RD0;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module txdesc_walker_chk #(
  parameter int AW = 32,
  parameter int IW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_en,
  input logic          txdma_en,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          mem_ack,
  input logic          seg_valid,
  input logic          seg_ready,
  input logic [31:0]   seg_addr,
  input logic [13:0]   seg_len,
  input logic [6:4]    status_set,
  input logic          misalign_err,
  input logic [IW-1:0] hp_idx,
  input logic [IW-1:0] np_idx,
  input logic          busy
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R13
  AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && !seg_ready |=> seg_valid && $stable(seg_addr) && $stable(seg_len)); // R13
  AST_WB_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[31]); // R4
  AST_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !(tx_en && txdma_en) |=> !mem_req); // R10
  AST_NP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    np_idx != $past(np_idx) |-> (np_idx == $past(np_idx) + 1'b1) || (np_idx == '0)); // R7
  AST_HP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    hp_idx != $past(hp_idx) |-> (hp_idx == $past(hp_idx) + 1'b1) || (hp_idx == '0)); // R7
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({seg_valid, mem_req})); // R13
  AST_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_err |-> $past(mem_ack && !mem_we && (mem_addr[3:0] != 4'd0))); // R11
  AST_STATUS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (|status_set) |-> $past(mem_ack)); // R5
endmodule

bind txdesc_walker txdesc_walker_chk #(.AW(AW), .IW(IW)) u_chk (.*);

// File: tb/txdesc_walker_tb.sv
module txdesc_walker_tb;
  logic        clk = 0, rst_n = 0, kick = 0, tx_en = 1, txdma_en = 1, hp_en = 0;
  logic [31:0] hp_base = 0, np_base = 0;
  logic        mem_req, mem_we, mem_ack = 0, seg_valid, seg_ready = 1, seg_hp;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0, seg_addr;
  logic [13:0] seg_len;
  logic        seg_first, seg_last, seg_crc_err, seg_vlan_en, misalign_err, busy;
  logic [15:0] seg_vlan_tag;
  logic [6:4]  status_set;
  logic [9:0]  hp_idx, np_idx;

  int checks = 0, errors = 0, cycles = 0;
  logic [31:0] mem [0:255];
  int seg_n = 0, n_phy = 0, n_fifo = 0, n_nobuf = 0, n_mis = 0, n_req = 0;
  logic [31:0] lg_addr [0:7];
  logic [31:0] lg_misc [0:7];
  logic        lg_hp   [0:7];

  txdesc_walker u_dut (.*);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    mem_ack <= mem_req && !mem_ack;
    if (mem_req && !mem_ack) begin
      mem_rdata <= mem[mem_addr[9:2]];
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    end
    if (mem_req) n_req <= n_req + 1;
    if (seg_valid && seg_ready) begin
      lg_addr[seg_n[2:0]] <= seg_addr;
      lg_misc[seg_n[2:0]] <= {seg_first, seg_last, seg_crc_err, seg_vlan_en, seg_vlan_tag[11:0], 2'b0, seg_len};
      lg_hp[seg_n[2:0]]   <= seg_hp;
      seg_n <= seg_n + 1;
    end
    if (status_set[4]) n_phy <= n_phy + 1;
    if (status_set[5]) n_fifo <= n_fifo + 1;
    if (status_set[6]) n_nobuf <= n_nobuf + 1;
    if (misalign_err) n_mis <= n_mis + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
  endtask

  task automatic put_desc(input int a, input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w3);
    mem[a/4] = w0; mem[a/4+1] = w1; mem[a/4+2] = 32'hDEAD_BEEF; mem[a/4+3] = w3;
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic do_kick();
    @(negedge clk) kick = 1;
    @(negedge clk) kick = 0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 hp_idx", hp_idx, 0);
    check("R1 np_idx", np_idx, 0);
    check("R1 outputs", {mem_req, seg_valid, busy, status_set, misalign_err}, 0);
  endtask

  task automatic t_single();
    int s0, f0, p0, b0;
    clear_mem(); hp_en = 0; hp_base = 0; np_base = 32'h200;
    put_desc(32'h200, 32'hB008_8040, 32'h4001_0ABC, 32'h0001_2344);
    do_reset();
    s0 = seg_n; f0 = n_fifo; p0 = n_phy; b0 = n_nobuf;
    do_kick();
    check("R3 seg count", seg_n - s0, 1);
    check("R2 R3 seg addr", lg_addr[s0[2:0]], 32'h0001_2344);
    check("R3 seg fields", lg_misc[s0[2:0]], {4'b1111, 12'hABC, 2'b0, 14'h0040});
    check("R4 writeback", mem[32'h200/4], 32'h3008_8040);
    check("R2 word2 untouched", mem[32'h208/4], 32'hDEAD_BEEF);
    check("R7 idx end-of-ring", np_idx, 0);
    check("R6 fifo pulse", f0 == n_fifo - 1, 1);
    check("R6 phy pulse", p0 == n_phy, 1);
    check("R5 nobuf pulse", b0 == n_nobuf - 1, 1);
  endtask

  task automatic t_priority();
    int s0, p0, b0;
    clear_mem(); hp_en = 1; hp_base = 32'h100; np_base = 32'h200;
    put_desc(32'h100, 32'h8000_0010, 32'h8000_0000, 32'hAAAA_0000);
    put_desc(32'h200, 32'h8000_0020, 32'h0000_0000, 32'hBBBB_0000);
    do_reset();
    s0 = seg_n; p0 = n_phy; b0 = n_nobuf;
    do_kick();
    check("R8 seg count", seg_n - s0, 2);
    check("R8 first urgent", lg_addr[s0[2:0]], 32'hAAAA_0000);
    check("R8 seg_hp", lg_hp[s0[2:0]], 1);
    check("R8 second normal", lg_addr[(s0+1)%8], 32'hBBBB_0000);
    check("R7 hp_idx inc", hp_idx, 1);
    check("R7 np_idx inc", np_idx, 1);
    check("R6 phy pulse", n_phy - p0, 1);
    check("R5 two stops", n_nobuf - b0, 2);
  endtask

  task automatic t_hp_off();
    int s0;
    clear_mem(); hp_en = 0; hp_base = 32'h100; np_base = 32'h200;
    put_desc(32'h100, 32'h8000_0010, 32'h0, 32'hAAAA_0000);
    put_desc(32'h200, 32'h8000_0020, 32'h0, 32'hBBBB_0000);
    do_reset();
    s0 = seg_n;
    do_kick();
    check("R9 seg count", seg_n - s0, 1);
    check("R9 normal only", lg_addr[s0[2:0]], 32'hBBBB_0000);
    check("R9 hp_idx kept", hp_idx, 0);
    check("R9 urgent desc kept", mem[32'h100/4], 32'h8000_0010);
  endtask

  task automatic t_wrap();
    int s0;
    clear_mem(); hp_en = 0; hp_base = 0; np_base = 32'h200;
    put_desc(32'h200, 32'h8000_0001, 32'h0, 32'h1000_0000);
    put_desc(32'h210, 32'h8000_8002, 32'h0, 32'h2000_0000);
    put_desc(32'h220, 32'h8000_0003, 32'h0, 32'h3000_0000);
    do_reset();
    s0 = seg_n;
    do_kick();
    check("R7 wrap segs", seg_n - s0, 2);
    check("R7 wrap idx", np_idx, 0);
    check("R7 beyond end untouched", mem[32'h220/4], 32'h8000_0003);
  endtask

  task automatic t_disabled();
    int r0, s0;
    clear_mem(); hp_en = 0; np_base = 32'h200;
    put_desc(32'h200, 32'h8000_0001, 32'h0, 32'h1000_0000);
    do_reset();
    tx_en = 0; r0 = n_req; s0 = seg_n;
    do_kick(); repeat (10) @(negedge clk);
    check("R10 no req tx_en", n_req - r0, 0);
    tx_en = 1; txdma_en = 0;
    do_kick(); repeat (10) @(negedge clk);
    check("R10 no req dma_en", n_req - r0, 0);
    check("R10 no seg", seg_n - s0, 0);
    check("R10 idx", np_idx, 0);
    txdma_en = 1;
  endtask

  task automatic t_misalign();
    int s0, m0;
    clear_mem(); hp_en = 0; np_base = 32'h204;
    put_desc(32'h204, 32'h8000_0005, 32'h0, 32'h5000_0000);
    do_reset();
    s0 = seg_n; m0 = n_mis;
    do_kick();
    check("R11 pulses", n_mis - m0, 2);
    check("R11 processed", seg_n - s0, 1);
    check("R11 writeback", mem[32'h204/4], 32'h0000_0005);
  endtask

  task automatic t_pending();
    int s0, b0;
    logic [31:0] a0;
    clear_mem(); hp_en = 0; np_base = 32'h200;
    put_desc(32'h200, 32'h8000_0007, 32'h0, 32'h7000_0000);
    do_reset();
    s0 = seg_n; b0 = n_nobuf;
    seg_ready = 0;
    @(negedge clk) kick = 1;
    @(negedge clk) kick = 0;
    while (!seg_valid) @(negedge clk);
    a0 = seg_addr;
    @(negedge clk) kick = 1;
    @(negedge clk) kick = 0;
    repeat (3) @(negedge clk);
    check("R13 seg held", seg_valid, 1);
    check("R13 seg stable", seg_addr, a0);
    seg_ready = 1;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    check("R12 one seg", seg_n - s0, 1);
    check("R12 second pass", n_nobuf - b0, 2);
  endtask

  initial begin
    t_reset();
    t_single();
    t_priority();
    t_hp_off();
    t_wrap();
    t_disabled();
    t_misalign();
    t_pending();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    errors++;
    $display("FAIL watchdog: actual %0d expected <100000", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule